// File: doc/BRIEF.md
# Smartcard Wait-Time Timer

This block measures the silent gaps on a smartcard line in block-transfer mode. It counts in bit times, driven by a one-cycle tick that a baud generator supplies at each bit boundary. After the reader sends a command, the block times the wait for the card's first answer character. Once software or the receiver reports that first character, it times the gap between each character and the next. Every end-of-character event restarts the count. When a gap runs past the programmed limit, a sticky timeout flag is set, and an interrupt line follows the flag if the interrupt is enabled.

The programmed limit is the wanted wait time less 11 bit times, which is the length of a character. The count starts at the end of the first stop bit of the last character. The end-of-character event arrives at the end of the whole frame. So with two stop bits, one bit time has already passed when the event arrives, and the block credits it. With one-and-a-half stop bits, the frame ends half a bit after the counting start, and the next bit tick completes the first counted bit. A phase output tells software whether the block wait or the character wait is being timed, so it knows which limit to load. The block carries no data stream. Every pin is a plain level or a single-cycle strobe with no handshake and no back-pressure.

Top module: `sc_wait_timer`

## Requirements
- R1: While reset is asserted, and after it is released, `timeout_flag`, `irq` and `char_phase` are 0.
- R2: With stop code 2'b00, the count starts at 0 on `char_end`, and `bit_tick` pulses each add one. The flag is set at the clock edge of the tick for which the elapsed count equals `wait_limit`, that is on the (limit+1)-th tick, so a limit of 0 expires on the first tick.
- R3: With stop code 2'b10 (two stop bits), the count starts at 1. The flag is set on the limit-th tick. A limit of 0 sets the flag one cycle after `char_end`, with no tick needed.
- R4: Stop codes 2'b11 (one and a half) and 2'b01 time exactly as 2'b00 does.
- R5: A `char_end` before expiry restarts the count. A `char_end` always takes precedence over a tick or an expiry in the same cycle, and that tick is not counted.
- R6: `char_phase` is 0 (block wait) whenever `enable` is low. It goes to 1 (character wait) the cycle after a `first_rx` pulse while `enable` is high, and stays at 1 until `enable` drops. A `first_rx` pulse while disabled has no effect.
- R7: `timeout_flag` stays set until a `flag_clr` strobe. If a clear and a new expiry occur in the same cycle, the flag stays set.
- R8: `irq` equals `timeout_flag` AND `irq_en`.
- R9: Each start point yields at most one expiry. Once it has expired, further ticks set no flag until the next `char_end`.
- R10: While `enable` is low, nothing is counted, `char_end` is ignored, and the flag is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Arms the timer; low stops it and returns to block wait |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| char_end | input | 1 | Pulse at the end of a character frame |
| stop_cfg | input | 2 | Stop bits: 00 one, 01 half, 10 two, 11 one and a half |
| wait_limit | input | LIMIT_W | Wanted wait minus 11, in bit times |
| first_rx | input | 1 | Pulse when the first answer character is received |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| timeout_flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request |
| char_phase | output | 1 | 0 block wait, 1 character wait |

## Verification
The bench builds the block with LIMIT_W of 8. This keeps the limits small, so expiries at limits of 0 to 5 happen within a few ticks. It also lets a random stream of ticks, ends, clears, phase pulses and stop codes reach many expiries, restarts and clear/expiry collisions. The directed cases put the two-stop credit, the zero limit and the coincident end-and-tick cycle next to one another. This shows that the credit shifts the expiry by exactly one tick.

// File: rtl/scwt_pkg.sv
package scwt_pkg;

  typedef enum logic [1:0] {
    STOP_ONE      = 2'b00,
    STOP_HALF     = 2'b01,
    STOP_TWO      = 2'b10,
    STOP_ONE_HALF = 2'b11
  } stop_mode_e;

  typedef enum logic {
    PH_BLOCK = 1'b0,
    PH_CHAR  = 1'b1
  } wait_phase_e;

  // Bit times already elapsed past the counting start when the frame ends.
  function automatic int unsigned stop_credit(input stop_mode_e mode);
    return (mode == STOP_TWO) ? 1 : 0;
  endfunction

endpackage

// File: rtl/scwt_start_align.sv
module scwt_start_align #(
  parameter int LIMIT_W = 24
) (
  input  logic [1:0]       stop_cfg,
  output logic [LIMIT_W:0] preload
);
  import scwt_pkg::*;

  localparam int CNT_W = LIMIT_W + 1;

  stop_mode_e mode;

  always_comb begin
    mode    = stop_mode_e'(stop_cfg);
    preload = CNT_W'(stop_credit(mode));
  end
endmodule

// File: rtl/scwt_elapsed_ctr.sv
module scwt_elapsed_ctr #(
  parameter int LIMIT_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic               restart,
  input  logic [LIMIT_W:0]   preload,
  input  logic [LIMIT_W-1:0] limit,
  output logic               hit
);
  localparam int CNT_W = LIMIT_W + 1;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_ext;
  logic             over;
  logic             at_edge;

  assign lim_ext = {1'b0, limit};

  always_comb begin
    over    = cnt_q > lim_ext;
    at_edge = tick && (cnt_q == lim_ext);
    hit     = en && run_q && !restart && (over || at_edge);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en) begin
      run_q <= 1'b0;
    end else if (restart) begin
      run_q <= 1'b1;
      cnt_q <= preload;
    end else if (hit) begin
      run_q <= 1'b0;
    end else if (run_q && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/scwt_phase_track.sv
module scwt_phase_track (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic first_rx,
  output logic char_phase
);
  import scwt_pkg::*;

  wait_phase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= PH_BLOCK;
    else if (!en)      phase_q <= PH_BLOCK;
    else if (first_rx) phase_q <= PH_CHAR;
  end

  assign char_phase = (phase_q == PH_CHAR);
endmodule

// File: rtl/scwt_flag_unit.sv
module scwt_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;
  assign irq  = flag_q & irq_en;
endmodule

// File: rtl/sc_wait_timer.sv
module sc_wait_timer #(
  parameter int LIMIT_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               bit_tick,
  input  logic               char_end,
  input  logic [1:0]         stop_cfg,
  input  logic [LIMIT_W-1:0] wait_limit,
  input  logic               first_rx,
  input  logic               irq_en,
  input  logic               flag_clr,
  output logic               timeout_flag,
  output logic               irq,
  output logic               char_phase
);
  logic [LIMIT_W:0] preload;
  logic             hit;

  scwt_start_align #(.LIMIT_W(LIMIT_W)) u_align (
    .stop_cfg (stop_cfg),
    .preload  (preload)
  );

  scwt_elapsed_ctr #(.LIMIT_W(LIMIT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (enable),
    .tick    (bit_tick),
    .restart (char_end),
    .preload (preload),
    .limit   (wait_limit),
    .hit     (hit)
  );

  scwt_phase_track u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (enable),
    .first_rx   (first_rx),
    .char_phase (char_phase)
  );

  scwt_flag_unit u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .clr    (flag_clr),
    .irq_en (irq_en),
    .flag   (timeout_flag),
    .irq    (irq)
  );
endmodule

// File: rtl/sc_wait_timer_chk.sv
module sc_wait_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic first_rx,
  input logic flag_clr,
  input logic irq_en,
  input logic timeout_flag,
  input logic irq,
  input logic char_phase
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!timeout_flag && !char_phase && !irq));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !flag_clr) |=> timeout_flag);

  a_r10_no_rise_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !$rose(timeout_flag));

  a_r6_phase_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !char_phase);

  a_r6_phase_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!char_phase && !first_rx) |=> !char_phase);

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind sc_wait_timer sc_wait_timer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .first_rx     (first_rx),
  .flag_clr     (flag_clr),
  .irq_en       (irq_en),
  .timeout_flag (timeout_flag),
  .irq          (irq),
  .char_phase   (char_phase)
);

// File: tb/sc_wait_timer_bench.sv
`timescale 1ns/100ps
module sc_wait_timer_bench;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          bit_tick = 1'b0;
  logic          char_end = 1'b0;
  logic [1:0]    stop_cfg = 2'b00;
  logic [LW-1:0] wait_limit = '0;
  logic          first_rx = 1'b0;
  logic          irq_en = 1'b0;
  logic          flag_clr = 1'b0;
  logic          timeout_flag, irq, char_phase;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sc_wait_timer #(.LIMIT_W(LW)) u_sc_wait_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bit_tick(bit_tick),
    .char_end(char_end), .stop_cfg(stop_cfg), .wait_limit(wait_limit),
    .first_rx(first_rx), .irq_en(irq_en), .flag_clr(flag_clr),
    .timeout_flag(timeout_flag), .irq(irq), .char_phase(char_phase)
  );

  // Behavioural reference: gap length in ticks since the counting start.
  int m_ticks;
  bit m_live, m_flag, m_phase, m_exp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ticks = 0; m_live = 0; m_flag = 0; m_phase = 0;
    end else begin
      m_exp = 0;
      if (enable && m_live && !char_end)
        m_exp = (m_ticks + (bit_tick ? 1 : 0)) > int'(wait_limit);
      if (!enable) begin
        m_live = 0; m_phase = 0;
      end else begin
        if (first_rx) m_phase = 1;
        if (char_end) begin
          m_live = 1;
          m_ticks = (stop_cfg == 2'b10) ? 1 : 0;
        end else if (m_exp) m_live = 0;
        else if (m_live && bit_tick) m_ticks++;
      end
      if (m_exp) m_flag = 1;
      else if (flag_clr) m_flag = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (timeout_flag !== m_flag) begin
        n_err++;
        $display("FAIL R7 model flag got %0b expected %0b", timeout_flag, m_flag);
      end
      n_chk++;
      if (irq !== (m_flag && irq_en)) begin
        n_err++;
        $display("FAIL R8 model irq got %0b expected %0b", irq, m_flag && irq_en);
      end
      n_chk++;
      if (char_phase !== m_phase) begin
        n_err++;
        $display("FAIL R6 model phase got %0b expected %0b", char_phase, m_phase);
      end
    end
  end

  task automatic step(input bit t, input bit ce, input bit fr, input bit cl);
    @(negedge clk);
    bit_tick = t; char_end = ce; first_rx = fr; flag_clr = cl;
    @(posedge clk);
    #0.5;
    bit_tick = 0; char_end = 0; first_rx = 0; flag_clr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic summary();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired got hang expected finish");
    summary();
  end

  initial begin
    #1;
    chk(timeout_flag, 1'b0, "R1 flag in reset");
    chk(char_phase, 1'b0, "R1 phase in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #0.5;
    chk(timeout_flag, 1'b0, "R1 flag after reset");
    chk(irq, 1'b0, "R1 irq after reset");
    chk(char_phase, 1'b0, "R1 phase after reset");

    // R2: one stop bit, limit 3 expires on the 4th tick
    enable = 1; wait_limit = 3; stop_cfg = 2'b00;
    step(0, 1, 0, 0);
    ticks(3);
    chk(timeout_flag, 1'b0, "R2 before limit");
    ticks(1);
    chk(timeout_flag, 1'b1, "R2 at limit+1 tick");
    chk(irq, 1'b0, "R8 irq masked");
    irq_en = 1; #0.1;
    chk(irq, 1'b1, "R8 irq enabled");
    step(0, 0, 0, 1);
    chk(timeout_flag, 1'b0, "R7 cleared");
    ticks(6);
    chk(timeout_flag, 1'b0, "R9 single expiry");

    // R2: limit 0
    wait_limit = 0;
    step(0, 1, 0, 0);
    chk(timeout_flag, 1'b0, "R2 zero limit before tick");
    ticks(1);
    chk(timeout_flag, 1'b1, "R2 zero limit first tick");
    step(0, 0, 0, 1);

    // R3: two stop bits credit one tick
    wait_limit = 3; stop_cfg = 2'b10;
    step(0, 1, 0, 0);
    ticks(2);
    chk(timeout_flag, 1'b0, "R3 two-stop before limit");
    ticks(1);
    chk(timeout_flag, 1'b1, "R3 two-stop at limit tick");
    step(0, 0, 0, 1);
    wait_limit = 0;
    step(0, 1, 0, 0);
    chk(timeout_flag, 1'b0, "R3 two-stop zero on end cycle");
    step(0, 0, 0, 0);
    chk(timeout_flag, 1'b1, "R3 two-stop zero without tick");
    step(0, 0, 0, 1);

    // R4: one-and-half and half codes time as one stop
    for (int k = 0; k < 2; k++) begin
      stop_cfg = (k == 0) ? 2'b11 : 2'b01; wait_limit = 2;
      step(0, 1, 0, 0);
      ticks(2);
      chk(timeout_flag, 1'b0, "R4 before limit");
      ticks(1);
      chk(timeout_flag, 1'b1, "R4 at limit+1 tick");
      step(0, 0, 0, 1);
    end

    // R5: restart and coincident end-with-tick
    stop_cfg = 2'b00; wait_limit = 3;
    step(0, 1, 0, 0);
    ticks(3);
    step(0, 1, 0, 0);
    ticks(3);
    chk(timeout_flag, 1'b0, "R5 restarted count");
    ticks(1);
    chk(timeout_flag, 1'b1, "R5 expiry after restart");
    step(0, 0, 0, 1);
    wait_limit = 1;
    step(1, 1, 0, 0);
    ticks(1);
    chk(timeout_flag, 1'b0, "R5 coincident tick not counted");
    ticks(1);
    chk(timeout_flag, 1'b1, "R5 expiry after coincident");

    // R7: clear and expiry in the same cycle
    wait_limit = 0;
    step(0, 1, 0, 0);
    step(1, 0, 0, 1);
    chk(timeout_flag, 1'b1, "R7 clear loses to expiry");
    step(0, 0, 0, 1);

    // R6: phase
    enable = 0;
    step(0, 0, 1, 0);
    chk(char_phase, 1'b0, "R6 first_rx ignored while disabled");
    enable = 1;
    step(0, 0, 1, 0);
    chk(char_phase, 1'b1, "R6 char phase");
    ticks(2);
    chk(char_phase, 1'b1, "R6 char phase holds");
    enable = 0;
    step(0, 0, 0, 0);
    chk(char_phase, 1'b0, "R6 back to block");

    // R10: disabled ignores ends and ticks
    wait_limit = 0;
    step(0, 1, 0, 0);
    ticks(4);
    chk(timeout_flag, 1'b0, "R10 disabled no expiry");

    // Random stream against the reference model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      enable     = ($urandom_range(0, 31) != 0);
      bit_tick   = ($urandom_range(0, 2) == 0);
      char_end   = ($urandom_range(0, 9) == 0);
      first_rx   = ($urandom_range(0, 19) == 0);
      flag_clr   = ($urandom_range(0, 7) == 0);
      irq_en     = ($urandom_range(0, 3) != 0);
      stop_cfg   = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) wait_limit = LW'($urandom_range(0, 5));
      @(posedge clk); #0.5;
    end
    bit_tick = 0; char_end = 0; first_rx = 0; flag_clr = 0;
    @(negedge clk);
    summary();
  end
endmodule